// File: doc/BRIEF.md
# Sub-Field Read Scheduler With Duty Control

The scheduler walks a bit-plane frame buffer in display order. Each cycle that `run` is high it issues one read address. Four counters make up that address. The area counter moves fastest. The column counter moves next, then the scan line counter. Slowest of all is a 19-step sub-field sequencer, which selects one of the 8 stored bit-plane fields.

The high-weight fields are shown by repeating whole steps. Field 7 is shown for eight steps, field 6 for four, field 5 for two and field 4 for one. Each of the four low-weight fields gets a single step. During that step the on-time is cut by a programmable comparator value.

The memory returns one word per read. The scheduler gathers the words of every area into a wide register. It publishes that register in one go with a single-cycle strobe, so all areas of the panel can light at the same moment. A `duty_en` output gates the scan enable of the drivers to set grey scale and brightness.

Top module: `subfield_read_sched`

## Requirements
- R1: `rd_addr` is {field[2:0], area, line, column}, from MSB to LSB. Each running cycle the area index rises by one and the other fields stay put. After AREAS-1 the area index returns to 0.
- R2: The column index advances only in a running cycle where the area index is AREAS-1. It wraps from COLS-1 to 0.
- R3: The line index advances only when area and column both wrap, and it wraps from LINES-1 to 0. The sub-field step advances only when area, column and line all wrap at once.
- R4: The step counts 0 to 18 and then returns to 0. Steps 0–7 address field 7, steps 8–11 field 6, steps 12–13 field 5 and step 14 field 4. Steps 15, 16, 17 and 18 address fields 3, 2, 1 and 0.
- R5: While the field being read is 4 to 7, `duty_en` is high.
- R6: While the field k being read is 0 to 3, `duty_en` is high exactly when pos < `on_time[k*PW +: PW]`. Here pos is the number of running cycles since the current step began (0 in its first cycle).
- R7: `rd_en` equals `run`. While `run` is low, `rd_addr` and `duty_en` hold their values.
- R8: A word on `rd_data` is sampled RD_LAT cycles after its read was issued. It lands in slice `area_bus[a*DATA_W +: DATA_W]`, where a is the area it was read for. When the word of area AREAS-1 lands, the whole bus updates and `bus_strobe` is high for exactly that one following cycle. `area_bus` changes at no other time.
- R9: After reset the address is all zero except field 7 (step 0), `rd_en` follows `run`, `bus_strobe` is low and `area_bus` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Advance the scan by one read this cycle |
| on_time | input | 4*PW | On-time limits for fields 0–3, slice k for field k |
| rd_en | output | 1 | Read request to the frame buffer |
| rd_addr | output | ADDR_W | Read address {field, area, line, column} |
| rd_data | input | DATA_W | Word returned by the frame buffer |
| area_bus | output | AREAS*DATA_W | Words for all areas, updated together |
| bus_strobe | output | 1 | One-cycle pulse when `area_bus` is updated |
| duty_en | output | 1 | Scan-enable duty signal for the current sub-field |

## Verification
Two complete 19-step frames run back to back. In the first frame the low-field on-times are halved down the weights. This separates a correct per-field comparator from one that uses the wrong slice or the wrong count. In the second frame the limits are 0, the full step length, one less than it, and 1. These settings catch off-by-one comparisons and step counters that fail to clear.

A pause in the middle of a row shows whether the counters, the duty count and the capture all freeze correctly. Every gathered bus is compared word by word with memory contents that depend on the address. This exposes any mix-up of area slots or of read latency.

// File: rtl/subfield_read_sched.sv
module subfield_read_sched #(
  parameter int AREAS  = 32,
  parameter int COLS   = 100,
  parameter int LINES  = 8,
  parameter int DATA_W = 24,
  parameter int RD_LAT = 1,
  localparam int AW = $clog2(AREAS),
  localparam int CW = $clog2(COLS),
  localparam int LW = $clog2(LINES),
  localparam int ADDR_W = 3 + AW + LW + CW,
  localparam int STEP_LEN = AREAS * COLS * LINES,
  localparam int PW = $clog2(STEP_LEN + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic [4*PW-1:0]          on_time,
  output logic                     rd_en,
  output logic [ADDR_W-1:0]        rd_addr,
  input  logic [DATA_W-1:0]        rd_data,
  output logic [AREAS*DATA_W-1:0]  area_bus,
  output logic                     bus_strobe,
  output logic                     duty_en
);

  logic [AW-1:0] area;
  logic [CW-1:0] col;
  logic [LW-1:0] line;
  logic [4:0]    step;
  logic [PW-1:0] pos;
  logic [2:0]    field;

  function automatic logic [2:0] step_field(input logic [4:0] s);
    if (s < 5'd8)       return 3'd7;
    else if (s < 5'd12) return 3'd6;
    else if (s < 5'd14) return 3'd5;
    else if (s == 5'd14) return 3'd4;
    else                return 3'(5'd18 - s);
  endfunction

  wire a_last   = area == AW'(AREAS - 1);
  wire c_last   = col  == CW'(COLS - 1);
  wire l_last   = line == LW'(LINES - 1);
  wire s_last   = step == 5'd18;
  wire step_end = a_last && c_last && l_last;

  assign field   = step_field(step);
  assign rd_en   = run;
  assign rd_addr = {field, area, line, col};
  assign duty_en = field[2] | (pos < on_time[field[1:0]*PW +: PW]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      area <= '0;
      col  <= '0;
      line <= '0;
      step <= '0;
      pos  <= '0;
    end else if (run) begin
      area <= a_last ? '0 : area + 1'b1;
      if (a_last)
        col <= c_last ? '0 : col + 1'b1;
      if (a_last && c_last)
        line <= l_last ? '0 : line + 1'b1;
      if (step_end)
        step <= s_last ? '0 : step + 1'b1;
      pos <= step_end ? '0 : pos + 1'b1;
    end
  end

  logic [RD_LAT-1:0] vld_sr;
  logic [AW-1:0]     area_sr [RD_LAT];
  logic [AREAS*DATA_W-1:0] hold;

  wire           vld_d  = vld_sr[RD_LAT-1];
  wire [AW-1:0]  area_d = area_sr[RD_LAT-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_sr <= '0;
      for (int i = 0; i < RD_LAT; i++) area_sr[i] <= '0;
    end else begin
      vld_sr[0]  <= run;
      area_sr[0] <= area;
      for (int i = 1; i < RD_LAT; i++) begin
        vld_sr[i]  <= vld_sr[i-1];
        area_sr[i] <= area_sr[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold       <= '0;
      area_bus   <= '0;
      bus_strobe <= 1'b0;
    end else begin
      bus_strobe <= vld_d && (area_d == AW'(AREAS - 1));
      if (vld_d) begin
        hold[area_d*DATA_W +: DATA_W] <= rd_data;
        if (area_d == AW'(AREAS - 1)) begin
          area_bus <= hold;
          area_bus[(AREAS-1)*DATA_W +: DATA_W] <= rd_data;
        end
      end
    end
  end

endmodule

// File: rtl/subfield_read_sched_chk.sv
module subfield_read_sched_chk #(
  parameter int AREAS = 32,
  parameter int COLS  = 100,
  parameter int LINES = 8,
  parameter int AW = 5,
  parameter int CW = 7,
  parameter int LW = 3,
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              bus_strobe,
  input logic              duty_en
);
  wire [2:0]    f = rd_addr[ADDR_W-1 -: 3];
  wire [AW-1:0] a = rd_addr[LW+CW +: AW];
  wire [LW-1:0] l = rd_addr[CW +: LW];
  wire [CW-1:0] c = rd_addr[0 +: CW];

  AST_AREA_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && a != AW'(AREAS-1) |=> a == $past(a) + 1'b1 && c == $past(c) && l == $past(l) && f == $past(f)); // R1
  AST_COL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    run && a == AW'(AREAS-1) && c != CW'(COLS-1) |=> a == '0 && c == $past(c) + 1'b1 && l == $past(l)); // R2
  AST_LINE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    run && a == AW'(AREAS-1) && c == CW'(COLS-1) && l != LW'(LINES-1) |=> c == '0 && l == $past(l) + 1'b1 && f == $past(f)); // R3
  AST_HIGH_FIELD_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    f[2] |-> duty_en); // R5
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(rd_addr) && $stable(duty_en)); // R7
  AST_RDEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en == run); // R7
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |=> !bus_strobe); // R8
endmodule

bind subfield_read_sched subfield_read_sched_chk #(
  .AREAS(AREAS), .COLS(COLS), .LINES(LINES),
  .AW(AW), .CW(CW), .LW(LW), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .rd_en(rd_en), .rd_addr(rd_addr),
  .bus_strobe(bus_strobe), .duty_en(duty_en)
);

// File: tb/subfield_read_sched_tb.sv
module subfield_read_sched_tb;
  localparam int A = 4, C = 5, L = 2, DW = 24;
  localparam int AW = $clog2(A), CW = $clog2(C), LW = $clog2(L);
  localparam int ADDR_W = 3 + AW + LW + CW;
  localparam int SL = A * C * L;
  localparam int PW = $clog2(SL + 1);

  logic clk = 0, rst_n = 0, run = 0;
  logic [4*PW-1:0] on_time;
  logic rd_en, bus_strobe, duty_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic [A*DW-1:0] area_bus;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [A*DW-1:0] expq[$];
  logic [A*DW-1:0] last_bus;
  int pushed = 0, popped = 0;

  always #2.5 clk = ~clk;

  subfield_read_sched #(.AREAS(A), .COLS(C), .LINES(L), .DATA_W(DW), .RD_LAT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .on_time(on_time), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .area_bus(area_bus),
    .bus_strobe(bus_strobe), .duty_en(duty_en));

  function automatic logic [DW-1:0] mem(input logic [ADDR_W-1:0] ad);
    return DW'(ad) * 24'd40503 + 24'd17;
  endfunction

  always_ff @(posedge clk) if (rd_en) rd_data <= mem(rd_addr);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] fmap(input int s);
    if (s < 8) return 3'd7;
    if (s < 12) return 3'd6;
    if (s < 14) return 3'd5;
    return 3'(18 - s);
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (bus_strobe) begin
        if (expq.size() == 0) chk("R8 unexpected strobe", 1, 0);
        else begin
          chk("R8 bus contents", area_bus, expq.pop_front());
          popped++;
        end
      end else if (area_bus !== last_bus) chk("R8 bus change without strobe", area_bus, last_bus);
      last_bus = area_bus;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [A*DW-1:0] acc;
    logic [ADDR_W-1:0] ea;
    logic [PW-1:0] ot;
    on_time = {PW'(SL/16), PW'(SL/8), PW'(SL/4), PW'(SL/2)};
    last_bus = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 strobe after reset", bus_strobe, 0);
    chk("R9 bus after reset", area_bus, 0);
    chk("R9 addr after reset", rd_addr, {3'd7, {(ADDR_W-3){1'b0}}});
    chk("R9 rd_en after reset", rd_en, 0);
    @(negedge clk);
    rst_n = 1;
    run = 1;
    for (int fr = 0; fr < 2; fr++) begin
      if (fr == 1) on_time = {PW'(1), PW'(SL-1), PW'(SL), PW'(0)};
      for (int s = 0; s < 19; s++)
        for (int ln = 0; ln < L; ln++)
          for (int co = 0; co < C; co++)
            for (int ar = 0; ar < A; ar++) begin
              ea = {fmap(s), AW'(ar), LW'(ln), CW'(co)};
              if (fr == 0 && s == 3 && ln == 0 && co == 2 && ar == 1) begin
                run = 0;
                repeat (4) begin
                  #1;
                  chk("R7 addr held while paused", rd_addr, ea);
                  chk("R7 rd_en low while paused", rd_en, 0);
                  @(negedge clk);
                end
                run = 1;
              end
              #1;
              chk(s == 0 ? "R1 R2 R3 address order" : "R4 step to field address", rd_addr, ea);
              chk("R7 rd_en", rd_en, 1);
              if (fmap(s) >= 4) chk("R5 high field duty", duty_en, 1);
              else begin
                ot = on_time[fmap(s)*PW +: PW];
                chk("R6 low field duty", duty_en, ((ln*C*A + co*A + ar) < ot));
              end
              acc[ar*DW +: DW] = mem(ea);
              if (ar == A-1) begin expq.push_back(acc); pushed++; end
              @(negedge clk);
            end
    end
    run = 0;
    repeat (4) @(negedge clk);
    chk("R8 every bus strobed", popped, pushed);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule